// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block holds the most recent virtual-page to physical-frame translations so that a load, store or instruction fetch can be translated without consulting the page tables. Each of its entries stores:

- a valid flag,
- a virtual page tag,
- a physical frame number,
- read, write and execute permission flags,
- a dirty flag.

A lookup is purely combinational. The caller presents a virtual address and an access type. In the same cycle the block reports exactly one outcome:

- a translated physical address,
- a permission fault,
- a dirty miss, meaning a write to a clean page whose table entry must first be marked dirty,
- a plain miss, meaning a page walk is required.

After a walk, the walker writes its result through the refill port. The refill overwrites an entry that already holds the same tag. Otherwise it goes into the lowest-numbered empty slot, or, when every slot is full, into the least recently used slot. Recency is tracked exactly.

Two coherency controls keep the cached contents honest. Any change on the page-table base input clears every entry. An invalidate request names one virtual page and clears only the entry that holds it.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is empty, so every lookup reports a miss.
- R2: A lookup whose page tag matches a valid entry and whose access is permitted reports a hit in the same cycle. The physical address is the stored frame number in the upper bits, joined to the 12-bit page offset of the virtual address (bits 11:0). When there is no hit, `lk_paddr_o` is zero.
- R3: When no valid entry matches, a lookup reports a miss. With `lk_valid_i` low, all four outcome outputs are low.
- R4: Access type encoding is 0 = read, 1 = write, 2 = execute, and 3 is treated as read. A matching lookup whose required permission flag is clear (read needs R, write needs W, execute needs X) reports a fault and no hit.
- R5: A write that matches a valid entry with W set and the dirty flag clear reports a dirty miss and no hit.
- R6: While `lk_valid_i` is high, exactly one of hit, miss, fault and dirty miss is asserted.
- R7: A refill accepted at a clock edge is visible to lookups from the next cycle. A lookup in the refill cycle still sees the old contents.
- R8: A refill whose tag is already present overwrites that entry, including its frame, permissions and dirty flag. No duplicate entry is created.
- R9: A refill with a new tag fills the lowest-indexed empty entry. When no entry is empty, it replaces the least recently used entry. An accepted refill makes its entry the most recent. A hit makes its entry the most recent, except in a cycle where a refill is accepted, when the hit does not change the recency order.
- R10: When `ptbr_i` differs from its value in the previous cycle (zero after reset), all entries are cleared at that edge, and any lookup in that same cycle reports a miss.
- R11: An invalidate request clears only the valid entry whose tag equals `inv_vpn_i`. All other entries keep hitting.
- R12: A refill in the same cycle as a base change or an invalidate request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Virtual address to translate |
| lk_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 read |
| lk_hit_o | output | 1 | Translation available |
| lk_paddr_o | output | 32 | Physical address on hit, zero otherwise |
| lk_fault_o | output | 1 | Permission fault |
| lk_dirty_miss_o | output | 1 | Write to a clean page, walk must set dirty |
| lk_miss_o | output | 1 | No valid matching entry |
| fill_valid_i | input | 1 | Refill request |
| fill_vpn_i | input | 20 | Refill virtual page tag |
| fill_pfn_i | input | 20 | Refill physical frame number |
| fill_r_i | input | 1 | Refill read permission |
| fill_w_i | input | 1 | Refill write permission |
| fill_x_i | input | 1 | Refill execute permission |
| fill_d_i | input | 1 | Refill dirty flag |
| inv_valid_i | input | 1 | Single-page invalidate request |
| inv_vpn_i | input | 20 | Page tag to invalidate |
| ptbr_i | input | 32 | Page-table base; any change flushes the block |

## Verification
Lookup outcomes and the physical address are combinational, so they are due in the same cycle as the request. The bench samples them one time unit after driving the inputs on the falling edge, before the next rising edge.

Refills, invalidates and flushes take effect at the next rising edge. The reference model applies them only after that edge, so a lookup in the same cycle is expected to see the old contents. The one exception is the flush-cycle miss, which is immediate.

The recency order is observed indirectly, by which tags still hit after a forced eviction.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
    logic d;
  } perm_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned NUM   = 16,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PFN_W = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                inv_i,
  input  logic [VPN_W-1:0]    inv_vpn_i,
  input  logic                wr_en_i,
  input  logic [NUM-1:0]      wr_sel_i,
  input  logic [VPN_W-1:0]    wr_vpn_i,
  input  logic [PFN_W-1:0]    wr_pfn_i,
  input  tlb_pkg::perm_t      wr_perm_i,
  input  logic [VPN_W-1:0]    lk_vpn_i,
  output logic [NUM-1:0]      lk_match_o,
  output logic [NUM-1:0]      fill_match_o,
  output logic [NUM-1:0]      valid_o,
  output logic [PFN_W-1:0]    lk_pfn_o,
  output tlb_pkg::perm_t      lk_perm_o
);
  logic [VPN_W-1:0]  vpn_q  [NUM];
  logic [PFN_W-1:0]  pfn_q  [NUM];
  tlb_pkg::perm_t    perm_q [NUM];

  for (genvar i = 0; i < NUM; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[i] <= 1'b0;
        vpn_q[i]   <= '0;
        pfn_q[i]   <= '0;
        perm_q[i]  <= '0;
      end else if (flush_i) begin
        valid_o[i] <= 1'b0;
      end else if (inv_i) begin
        if (vpn_q[i] == inv_vpn_i) valid_o[i] <= 1'b0;
      end else if (wr_en_i && wr_sel_i[i]) begin
        valid_o[i] <= 1'b1;
        vpn_q[i]   <= wr_vpn_i;
        pfn_q[i]   <= wr_pfn_i;
        perm_q[i]  <= wr_perm_i;
      end
    end

    assign lk_match_o[i]   = valid_o[i] && (vpn_q[i] == lk_vpn_i);
    assign fill_match_o[i] = valid_o[i] && (vpn_q[i] == wr_vpn_i);
  end

  // at most one match, so an OR mux suffices
  always_comb begin
    lk_pfn_o  = '0;
    lk_perm_o = '0;
    for (int i = 0; i < NUM; i++) begin
      if (lk_match_o[i]) begin
        lk_pfn_o  = lk_pfn_o | pfn_q[i];
        lk_perm_o = lk_perm_o | perm_q[i];
      end
    end
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int unsigned NUM = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           touch_i,
  input  logic [NUM-1:0] touch_sel_i,
  output logic [NUM-1:0] victim_o
);
  localparam int unsigned AW = (NUM > 1) ? $clog2(NUM) : 1;

  logic [AW-1:0] age_q [NUM];
  logic [AW-1:0] touched_age;

  always_comb begin
    touched_age = '0;
    for (int i = 0; i < NUM; i++) begin
      if (touch_sel_i[i]) touched_age = touched_age | age_q[i];
    end
  end

  // ages stay a permutation of 0..NUM-1; oldest has NUM-1
  for (genvar i = 0; i < NUM; i++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[i] <= AW'(i);
      end else if (touch_i) begin
        if (touch_sel_i[i])              age_q[i] <= '0;
        else if (age_q[i] < touched_age) age_q[i] <= age_q[i] + 1'b1;
      end
    end
    assign victim_o[i] = (age_q[i] == AW'(NUM - 1));
  end
endmodule

// File: rtl/tlb_fill_sel.sv
module tlb_fill_sel #(
  parameter int unsigned NUM = 16
) (
  input  logic [NUM-1:0] same_tag_i,
  input  logic [NUM-1:0] valid_i,
  input  logic [NUM-1:0] victim_i,
  output logic [NUM-1:0] sel_o
);
  logic [NUM-1:0] free_sel;
  logic           found;

  always_comb begin
    free_sel = '0;
    found    = 1'b0;
    for (int i = 0; i < NUM; i++) begin
      if (!valid_i[i] && !found) begin
        free_sel[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  always_comb begin
    if (|same_tag_i) sel_o = same_tag_i;
    else if (found)  sel_o = free_sel;
    else             sel_o = victim_i;
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned VPN_W       = 20,
  parameter int unsigned PFN_W       = 20,
  parameter int unsigned OFF_W       = 12,
  parameter int unsigned PTBR_W      = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    lk_valid_i,
  input  logic [VPN_W+OFF_W-1:0]  lk_vaddr_i,
  input  logic [1:0]              lk_acc_i,
  output logic                    lk_hit_o,
  output logic [PFN_W+OFF_W-1:0]  lk_paddr_o,
  output logic                    lk_fault_o,
  output logic                    lk_dirty_miss_o,
  output logic                    lk_miss_o,
  input  logic                    fill_valid_i,
  input  logic [VPN_W-1:0]        fill_vpn_i,
  input  logic [PFN_W-1:0]        fill_pfn_i,
  input  logic                    fill_r_i,
  input  logic                    fill_w_i,
  input  logic                    fill_x_i,
  input  logic                    fill_d_i,
  input  logic                    inv_valid_i,
  input  logic [VPN_W-1:0]        inv_vpn_i,
  input  logic [PTBR_W-1:0]       ptbr_i
);
  import tlb_pkg::*;

  localparam int unsigned VA_W = VPN_W + OFF_W;

  logic [PTBR_W-1:0]      ptbr_q;
  logic                   flush;
  logic                   fill_acc;
  logic [VPN_W-1:0]       lk_vpn;
  logic [OFF_W-1:0]       lk_off;
  logic [NUM_ENTRIES-1:0] lk_match, fill_match, valid, victim, fill_sel, touch_sel;
  logic [PFN_W-1:0]       lk_pfn;
  perm_t                  lk_perm, fill_perm;
  logic                   tag_hit, perm_ok, is_write, need_dirty, touch;
  acc_e                   acc;

  assign lk_vpn = lk_vaddr_i[VA_W-1:OFF_W];
  assign lk_off = lk_vaddr_i[OFF_W-1:0];
  assign acc    = acc_e'(lk_acc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptbr_q <= '0;
    else         ptbr_q <= ptbr_i;
  end

  assign flush    = (ptbr_i != ptbr_q);
  assign fill_acc = fill_valid_i && !flush && !inv_valid_i;

  assign fill_perm = '{r: fill_r_i, w: fill_w_i, x: fill_x_i, d: fill_d_i};

  tlb_cam #(
    .NUM   (NUM_ENTRIES),
    .VPN_W (VPN_W),
    .PFN_W (PFN_W)
  ) u_cam (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush),
    .inv_i        (inv_valid_i),
    .inv_vpn_i    (inv_vpn_i),
    .wr_en_i      (fill_acc),
    .wr_sel_i     (fill_sel),
    .wr_vpn_i     (fill_vpn_i),
    .wr_pfn_i     (fill_pfn_i),
    .wr_perm_i    (fill_perm),
    .lk_vpn_i     (lk_vpn),
    .lk_match_o   (lk_match),
    .fill_match_o (fill_match),
    .valid_o      (valid),
    .lk_pfn_o     (lk_pfn),
    .lk_perm_o    (lk_perm)
  );

  tlb_fill_sel #(.NUM(NUM_ENTRIES)) u_sel (
    .same_tag_i (fill_match),
    .valid_i    (valid),
    .victim_i   (victim),
    .sel_o      (fill_sel)
  );

  always_comb begin
    unique case (acc)
      ACC_WRITE: perm_ok = lk_perm.w;
      ACC_EXEC:  perm_ok = lk_perm.x;
      default:   perm_ok = lk_perm.r;
    endcase
  end

  // stale context: a base change masks every match this cycle
  assign tag_hit    = (|lk_match) && !flush;
  assign is_write   = (acc == ACC_WRITE);
  assign need_dirty = is_write && !lk_perm.d;

  assign lk_miss_o       = lk_valid_i && !tag_hit;
  assign lk_fault_o      = lk_valid_i && tag_hit && !perm_ok;
  assign lk_dirty_miss_o = lk_valid_i && tag_hit && perm_ok && need_dirty;
  assign lk_hit_o        = lk_valid_i && tag_hit && perm_ok && !need_dirty;
  assign lk_paddr_o      = lk_hit_o ? {lk_pfn, lk_off} : '0;

  assign touch     = fill_acc || lk_hit_o;
  assign touch_sel = fill_acc ? fill_sel : lk_match;

  tlb_lru #(.NUM(NUM_ENTRIES)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch),
    .touch_sel_i (touch_sel),
    .victim_o    (victim)
  );
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PTBR_W = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   lk_valid_i,
  input logic [VPN_W+OFF_W-1:0] lk_vaddr_i,
  input logic                   lk_hit_o,
  input logic [OFF_W-1:0]       lk_paddr_off,
  input logic                   lk_fault_o,
  input logic                   lk_dirty_miss_o,
  input logic                   lk_miss_o,
  input logic                   fill_valid_i,
  input logic [VPN_W-1:0]       fill_vpn_i,
  input logic                   inv_valid_i,
  input logic [VPN_W-1:0]       inv_vpn_i,
  input logic [PTBR_W-1:0]      ptbr_i
);
  localparam int unsigned VA_W = VPN_W + OFF_W;

  logic [PTBR_W-1:0] base_prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_prev <= '0;
    else         base_prev <= ptbr_i;
  end

  logic [VPN_W-1:0] vpn;
  logic             base_same, took_fill;
  assign vpn       = lk_vaddr_i[VA_W-1:OFF_W];
  assign base_same = (ptbr_i == base_prev);
  assign took_fill = fill_valid_i && !inv_valid_i && base_same;

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |-> $countones({lk_hit_o, lk_miss_o, lk_fault_o, lk_dirty_miss_o}) == 1); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !(lk_hit_o || lk_miss_o || lk_fault_o || lk_dirty_miss_o)); // R3

  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_paddr_off == lk_vaddr_i[OFF_W-1:0]); // R2

  AST_FLUSH_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !base_same) |-> lk_miss_o); // R10

  AST_FILL_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    took_fill |=> !(lk_valid_i && base_same && vpn == $past(fill_vpn_i)) || !lk_miss_o); // R7

  AST_INV_GONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_i |=> !(lk_valid_i && vpn == $past(inv_vpn_i)) || lk_miss_o); // R11

  AST_FILL_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !base_same) |=> !(lk_valid_i && vpn == $past(fill_vpn_i)) || lk_miss_o); // R12
endmodule

bind tlb_fa tlb_fa_chk #(
  .VPN_W  (VPN_W),
  .OFF_W  (OFF_W),
  .PTBR_W (PTBR_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .lk_valid_i      (lk_valid_i),
  .lk_vaddr_i      (lk_vaddr_i),
  .lk_hit_o        (lk_hit_o),
  .lk_paddr_off    (lk_paddr_o[OFF_W-1:0]),
  .lk_fault_o      (lk_fault_o),
  .lk_dirty_miss_o (lk_dirty_miss_o),
  .lk_miss_o       (lk_miss_o),
  .fill_valid_i    (fill_valid_i),
  .fill_vpn_i      (fill_vpn_i),
  .inv_valid_i     (inv_valid_i),
  .inv_vpn_i       (inv_vpn_i),
  .ptbr_i          (ptbr_i)
);

// File: tb/tb_tlb_fa.sv
module tb_tlb_fa;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i = 1'b0;
  logic [31:0] lk_vaddr_i = '0;
  logic [1:0]  lk_acc_i = '0;
  logic        lk_hit_o, lk_fault_o, lk_dirty_miss_o, lk_miss_o;
  logic [31:0] lk_paddr_o;
  logic        fill_valid_i = 1'b0;
  logic [19:0] fill_vpn_i = '0, fill_pfn_i = '0;
  logic        fill_r_i = 1'b0, fill_w_i = 1'b0, fill_x_i = 1'b0, fill_d_i = 1'b0;
  logic        inv_valid_i = 1'b0;
  logic [19:0] inv_vpn_i = '0;
  logic [31:0] ptbr_i = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tlb_fa dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid_i), .lk_vaddr_i(lk_vaddr_i), .lk_acc_i(lk_acc_i),
    .lk_hit_o(lk_hit_o), .lk_paddr_o(lk_paddr_o), .lk_fault_o(lk_fault_o),
    .lk_dirty_miss_o(lk_dirty_miss_o), .lk_miss_o(lk_miss_o),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_pfn_i(fill_pfn_i),
    .fill_r_i(fill_r_i), .fill_w_i(fill_w_i), .fill_x_i(fill_x_i), .fill_d_i(fill_d_i),
    .inv_valid_i(inv_valid_i), .inv_vpn_i(inv_vpn_i), .ptbr_i(ptbr_i)
  );

  // behavioural reference: entry table plus a recency queue (front = newest)
  bit          m_v [N];
  logic [19:0] m_vpn [N], m_pfn [N];
  bit          m_r [N], m_w [N], m_x [N], m_d [N];
  int          order [$];
  logic [31:0] m_base;

  function automatic int find(logic [19:0] vpn);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic logic [35:0] expect_out();
    int k;
    bit ok, h, m, f, dm;
    logic [31:0] pa;
    h = 0; m = 0; f = 0; dm = 0; pa = '0;
    if (lk_valid_i) begin
      k = (ptbr_i != m_base) ? -1 : find(lk_vaddr_i[31:12]);
      if (k < 0) m = 1;
      else begin
        ok = (lk_acc_i == 2'd1) ? m_w[k] : (lk_acc_i == 2'd2) ? m_x[k] : m_r[k];
        if (!ok) f = 1;
        else if (lk_acc_i == 2'd1 && !m_d[k]) dm = 1;
        else begin h = 1; pa = {m_pfn[k], lk_vaddr_i[11:0]}; end
      end
    end
    return {h, m, f, dm, pa};
  endfunction

  task automatic touch(int k);
    for (int p = 0; p < order.size(); p++)
      if (order[p] == k) begin order.delete(p); break; end
    order.push_front(k);
  endtask

  task automatic model_edge(bit hit_now);
    int k;
    bit took;
    took = 0;
    if (ptbr_i != m_base) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else if (inv_valid_i) begin
      k = find(inv_vpn_i);
      if (k >= 0) m_v[k] = 0;
    end else if (fill_valid_i) begin
      took = 1;
      k = find(fill_vpn_i);
      if (k < 0) for (int i = 0; i < N; i++) if (!m_v[i]) begin k = i; break; end
      if (k < 0) k = order[$];
      m_v[k] = 1; m_vpn[k] = fill_vpn_i; m_pfn[k] = fill_pfn_i;
      m_r[k] = fill_r_i; m_w[k] = fill_w_i; m_x[k] = fill_x_i; m_d[k] = fill_d_i;
      touch(k);
    end
    // hit recency is skipped in a refill cycle (R9); inv may clear the same entry
    if (hit_now && !took) touch(find_any(lk_vaddr_i[31:12]));
    m_base = ptbr_i;
  endtask

  function automatic int find_any(logic [19:0] vpn);
    for (int i = 0; i < N; i++) if (m_vpn[i] == vpn && (m_v[i] || (inv_valid_i && inv_vpn_i == vpn))) return i;
    return 0;
  endfunction

  task automatic cyc(input string tag);
    logic [35:0] exp_o, got;
    #1;
    exp_o = expect_out();
    got   = {lk_hit_o, lk_miss_o, lk_fault_o, lk_dirty_miss_o, lk_paddr_o};
    n_chk++;
    if (got !== exp_o) begin
      n_fail++;
      $display("FAIL %s: got hit/miss/fault/dmiss/pa %h expected %h", tag, got, exp_o);
    end
    @(posedge clk);
    model_edge(exp_o[35]);
    @(negedge clk);
    lk_valid_i = 0; fill_valid_i = 0; inv_valid_i = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] a);
    lk_valid_i = 1; lk_vaddr_i = va; lk_acc_i = a;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [3:0] rwxd);
    fill_valid_i = 1; fill_vpn_i = vpn; fill_pfn_i = pfn;
    {fill_r_i, fill_w_i, fill_x_i, fill_d_i} = rwxd;
  endtask

  task automatic inval(input logic [19:0] vpn);
    inv_valid_i = 1; inv_vpn_i = vpn;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0;
      m_r[i] = 0; m_w[i] = 0; m_x[i] = 0; m_d[i] = 0;
      order.push_back(i);
    end
    m_base = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1: empty after reset
    look(32'h1234_5678, 2'd0); cyc("R1");
    look(32'h0000_0000, 2'd2); cyc("R1");
    cyc("R3");                                      // idle: all outcomes low
    // R7: refill, same-cycle lookup still misses
    fill(20'h00010, 20'h00ABC, 4'b1111); look(32'h0001_044C, 2'd0); cyc("R7");
    look(32'h0001_044C, 2'd0); cyc("R2");
    look(32'h0001_0FFF, 2'd2); cyc("R2");
    look(32'h0001_0000, 2'd1); cyc("R2");
    look(32'h0001_0123, 2'd3); cyc("R4");           // code 3 behaves as read
    // R4: read-only page
    fill(20'h00020, 20'h00DEF, 4'b1000); cyc("R7");
    look(32'h0002_0010, 2'd1); cyc("R4");
    look(32'h0002_0010, 2'd2); cyc("R4");
    look(32'h0002_0010, 2'd0); cyc("R6");
    // R5: clean writable page
    fill(20'h00030, 20'h00111, 4'b1100); cyc("R7");
    look(32'h0003_0ABC, 2'd1); cyc("R5");
    look(32'h0003_0ABC, 2'd0); cyc("R5");
    // R8: same-tag refill overwrites
    fill(20'h00030, 20'h00222, 4'b1101); cyc("R8");
    look(32'h0003_0ABC, 2'd1); cyc("R8");
    inval(20'h00030); look(32'h0001_0008, 2'd0); cyc("R11");
    look(32'h0003_0ABC, 2'd0); cyc("R8");           // no duplicate left behind
    look(32'h0001_0008, 2'd0); cyc("R11");
    inval(20'h00010); cyc("R11");
    look(32'h0001_0008, 2'd0); cyc("R11");
    look(32'h0002_0008, 2'd0); cyc("R11");
    // R10: base change flushes, same-cycle lookup misses
    ptbr_i = 32'h0000_1000; look(32'h0002_0008, 2'd0); cyc("R10");
    look(32'h0002_0008, 2'd0); cyc("R10");
    // R9: fill all entries, then force evictions
    for (int i = 0; i < N; i++) begin
      fill(20'h00100 + 20'(i), 20'h00500 + 20'(i), 4'b1111); cyc("R9");
    end
    look(32'h0010_0000, 2'd0); cyc("R9");           // entry with 0x100 becomes newest
    fill(20'h00200, 20'h00777, 4'b1111); look(32'h0010_2000, 2'd0); cyc("R9");
    fill(20'h00300, 20'h00888, 4'b1111); cyc("R9");
    look(32'h0010_1004, 2'd0); cyc("R9");
    look(32'h0010_2004, 2'd0); cyc("R9");
    look(32'h0010_0004, 2'd0); cyc("R9");
    look(32'h0020_0004, 2'd0); cyc("R9");
    look(32'h0030_0004, 2'd0); cyc("R9");
    look(32'h0010_3004, 2'd0); cyc("R9");
    // R12: refill dropped under flush or invalidate
    fill(20'h00400, 20'h00999, 4'b1111); ptbr_i = 32'h0000_2000; cyc("R12");
    look(32'h0040_0000, 2'd0); cyc("R12");
    look(32'h0010_3004, 2'd0); cyc("R10");
    fill(20'h00410, 20'h00AAA, 4'b1111); cyc("R7");
    fill(20'h00420, 20'h00BBB, 4'b1111); inval(20'h00410); cyc("R12");
    look(32'h0042_0000, 2'd0); cyc("R12");
    look(32'h0041_0000, 2'd0); cyc("R11");
    cyc("R3");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule